// File: doc/BRIEF.md
# Automatic Level Controller for a Mono Sample Stream

This block scales a signed 16-bit mono audio stream by a programmable gain and adjusts that gain by itself. One sample comes in with each sample-rate strobe. The block multiplies it by the gain in effect, saturates the result and registers it. The gain is held as an 8-bit code with a 0.375 dB step, and the same code is shown on an output so that it can be read back.

When automatic control is off, the gain code comes straight from a manual volume input. When it is on, the block runs as a two-phase loop.

- **Limiter phase:** every sample whose scaled magnitude is above the selected threshold pulls the gain down by one code.
- **Recovery phase:** once a chosen number of samples have passed with no such crossing, the gain rises by a selectable step. It rises toward a reference code and never goes past it.
- **Wait restart:** a crossing that occurs during the wait starts the wait again.

Threshold, wait length, step size and reference are only changed while automatic control is off.

Top module: `alc_core`

## Requirements
- R1: Gain code 1 is -54 dB and each code above it adds 0.375 dB, so code 145 is 0 dB and code 241 is +36 dB. Codes above 241 act as 241. For every code c with (c-1) a multiple of 16, the output is exactly floor(x * 2^((c-145)/16)).
- R2: `outValid` is high in the cycle after each `sampleValid` pulse and low otherwise. `sampleOut` then holds that sample scaled by the gain code that was current when the sample arrived.
- R3: The scaled result saturates to the range -32768..32767.
- R4: Gain code 0 is mute and forces `sampleOut` to 0.
- R5: While `alcEnable` is low, `gainCode` equals the `manualGain` value of the previous clock, and no automatic change happens.
- R6: While enabled, a sample whose scaled magnitude exceeds 16384 + 4096*`thrSel` lowers the gain code by one at that sample. The code never drops below 1.
- R7: While enabled, a recovery step happens on the N-th consecutive non-crossing sample after the last crossing (or after enabling), where N = 4 << `waitSel`. A crossing restarts the count, and clock cycles without a sample do not advance it.
- R8: A recovery step adds `stepSel`+1 codes, clamped to `refGain`. When the gain is already at or above `refGain`, it does not change.
- R9: While enabled, `gainCode` changes only in the cycle after a sample strobe.
- R10: After reset, `gainCode` is 145, `outValid` is 0 and `sampleOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe per sample period |
| sampleIn | input | 16 | Signed input sample |
| alcEnable | input | 1 | Automatic gain control on |
| thrSel | input | 2 | Limiter threshold select |
| waitSel | input | 2 | Recovery wait length select |
| stepSel | input | 2 | Recovery step size select |
| refGain | input | 8 | Recovery ceiling gain code |
| manualGain | input | 8 | Gain code used while disabled |
| sampleOut | output | 16 | Scaled, saturated sample |
| outValid | output | 1 | Strobe marking a new `sampleOut` |
| gainCode | output | 8 | Current gain code |

## Verification
The properties assume that the threshold, wait, step and reference fields stay steady while `alcEnable` is high. They also assume that strobes are single-cycle pulses. The stimulus sets every control field with automatic control off and only then raises `alcEnable`. It drives each sample as a pulse that lasts exactly one clock, with at least one idle cycle before the next. The gain bounds asserted for recovery hold because the reference is never moved during an enabled stretch.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 8;
  localparam logic [GAIN_W-1:0] GAIN_MUTE  = 8'd0;
  localparam logic [GAIN_W-1:0] GAIN_MIN   = 8'd1;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = 8'd145;
  localparam logic [GAIN_W-1:0] GAIN_TOP   = 8'd241;

  // control-to-datapath strobes
  typedef struct packed {
    logic              capture;
    logic [GAIN_W-1:0] gain;
  } alcStrobe_t;

  // 1.0 .. ~1.91 in Q15 (unsigned 16 bits), one entry per 0.375 dB inside an octave
  function automatic logic [15:0] stepMantissa(input logic [3:0] idx);
    case (idx)
      4'd0:  return 16'd32768;
      4'd1:  return 16'd34214;
      4'd2:  return 16'd35723;
      4'd3:  return 16'd37299;
      4'd4:  return 16'd38945;
      4'd5:  return 16'd40663;
      4'd6:  return 16'd42457;
      4'd7:  return 16'd44330;
      4'd8:  return 16'd46287;
      4'd9:  return 16'd48329;
      4'd10: return 16'd50461;
      4'd11: return 16'd52688;
      4'd12: return 16'd55012;
      4'd13: return 16'd57439;
      4'd14: return 16'd59973;
      default: return 16'd62619;
    endcase
  endfunction
endpackage

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int THR_BASE = 16384,
  parameter int THR_STEP = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  alcStrobe_t        strb,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [1:0]        thrSel,
  output logic [DATA_W-1:0] sampleOut,
  output logic              outValid,
  output logic              overThr
);
  localparam int PROD_W = DATA_W + 17;
  localparam int MAG_W  = DATA_W + 1;
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] NEG_LIM = -POS_LIM - 1;

  logic [GAIN_W-1:0]        code;
  logic [GAIN_W-1:0]        codeIdx;
  logic [15:0]              mant;
  logic [4:0]               shAmt;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] shifted;
  logic [DATA_W-1:0]        scaled;
  logic [MAG_W-1:0]         mag;
  logic [MAG_W-1:0]         thr;

  always_comb begin
    code    = (strb.gain > GAIN_TOP) ? GAIN_TOP : strb.gain;
    codeIdx = code - GAIN_MIN;
    mant    = stepMantissa(codeIdx[3:0]);
    shAmt   = 5'd24 - {1'b0, codeIdx[7:4]};
    product = $signed(sampleIn) * $signed({1'b0, mant});
    shifted = product >>> shAmt;
    if (code == GAIN_MUTE)      scaled = '0;
    else if (shifted > POS_LIM) scaled = POS_LIM[DATA_W-1:0];
    else if (shifted < NEG_LIM) scaled = NEG_LIM[DATA_W-1:0];
    else                        scaled = shifted[DATA_W-1:0];
    mag     = scaled[DATA_W-1] ? (~{1'b1, scaled} + MAG_W'(1)) : {1'b0, scaled};
    thr     = MAG_W'(THR_BASE) + MAG_W'(THR_STEP) * MAG_W'(thrSel);
    overThr = mag > thr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strb.capture;
      if (strb.capture) sampleOut <= scaled;
    end
  end
endmodule

// File: rtl/alc_control.sv
module alc_control
  import alc_pkg::*;
#(
  parameter int WAIT_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              overThr,
  input  logic              alcEnable,
  input  logic [1:0]        waitSel,
  input  logic [1:0]        stepSel,
  input  logic [GAIN_W-1:0] refGain,
  input  logic [GAIN_W-1:0] manualGain,
  output alcStrobe_t        strb,
  output logic [GAIN_W-1:0] gainCode
);
  localparam int CNT_W = $clog2(WAIT_BASE * 8) + 1;

  logic [CNT_W-1:0]  waitCnt;
  logic [CNT_W-1:0]  waitLen;
  logic [GAIN_W:0]   stepSum;
  logic [GAIN_W-1:0] raised;
  logic [GAIN_W-1:0] gainReg;

  always_comb begin
    waitLen = CNT_W'(WAIT_BASE) << waitSel;
    stepSum = {1'b0, gainReg} + {{(GAIN_W-1){1'b0}}, stepSel} + (GAIN_W+1)'(1);
    raised  = (stepSum > {1'b0, refGain}) ? refGain : stepSum[GAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainReg <= GAIN_UNITY;
      waitCnt <= '0;
    end else if (!alcEnable) begin
      gainReg <= manualGain;
      waitCnt <= '0;
    end else if (sampleValid) begin
      if (overThr) begin
        if (gainReg > GAIN_MIN) gainReg <= gainReg - GAIN_MIN;
        waitCnt <= '0;
      end else if (waitCnt == waitLen - CNT_W'(1)) begin
        waitCnt <= '0;
        if (gainReg < refGain) gainReg <= raised;
      end else begin
        waitCnt <= waitCnt + CNT_W'(1);
      end
    end
  end

  assign strb.capture = sampleValid;
  assign strb.gain    = gainReg;
  assign gainCode     = gainReg;
endmodule

// File: rtl/alc_core.sv
module alc_core
  import alc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WAIT_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              alcEnable,
  input  logic [1:0]        thrSel,
  input  logic [1:0]        waitSel,
  input  logic [1:0]        stepSel,
  input  logic [7:0]        refGain,
  input  logic [7:0]        manualGain,
  output logic [DATA_W-1:0] sampleOut,
  output logic              outValid,
  output logic [7:0]        gainCode
);
  alcStrobe_t strb;
  logic       overThr;

  alc_control #(.WAIT_BASE(WAIT_BASE)) ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .overThr(overThr),
    .alcEnable(alcEnable), .waitSel(waitSel), .stepSel(stepSel),
    .refGain(refGain), .manualGain(manualGain), .strb(strb), .gainCode(gainCode)
  );

  alc_datapath #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn), .thrSel(thrSel),
    .sampleOut(sampleOut), .outValid(outValid), .overThr(overThr)
  );
endmodule

// File: rtl/alc_core_checker.sv
module alc_core_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              alcEnable,
  input logic [7:0]        manualGain,
  input logic [7:0]        refGain,
  input logic [7:0]        gainCode,
  input logic              outValid,
  input logic [DATA_W-1:0] sampleOut
);
  logic warm;
  always_ff @(posedge clk) warm <= rstN;

  // R2: output strobe follows input strobe by one clock
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN || !warm)
    outValid == $past(sampleValid));

  // R4: a sample taken under mute leaves a zero output
  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rstN || !warm)
    (outValid && $past(gainCode) == 8'd0) |-> sampleOut == '0);

  // R5: manual gain tracks with one clock of delay
  assert_manual_track_R5: assert property (@(posedge clk) disable iff (!rstN || !warm)
    !$past(alcEnable) |-> gainCode == $past(manualGain));

  // R6: limiter lowers by at most one code
  assert_down_one_R6: assert property (@(posedge clk) disable iff (!rstN || !warm)
    (alcEnable && $past(alcEnable)) |-> ({1'b0, gainCode} + 9'd1 >= {1'b0, $past(gainCode)}));

  // R6: limiter never enters mute
  assert_no_mute_entry_R6: assert property (@(posedge clk) disable iff (!rstN || !warm)
    (alcEnable && $past(alcEnable) && $past(gainCode) != 8'd0) |-> gainCode != 8'd0);

  // R8: a rise is at most four codes and ends at or below the reference
  assert_rise_bound_R8: assert property (@(posedge clk) disable iff (!rstN || !warm)
    (alcEnable && $past(alcEnable) && gainCode > $past(gainCode)) |->
      (gainCode <= refGain && {1'b0, gainCode} <= {1'b0, $past(gainCode)} + 9'd4));

  // R9: no change without a sample while enabled
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN || !warm)
    (alcEnable && $past(alcEnable) && !$past(sampleValid)) |-> $stable(gainCode));
endmodule

bind alc_core alc_core_checker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .alcEnable(alcEnable),
  .manualGain(manualGain), .refGain(refGain), .gainCode(gainCode),
  .outValid(outValid), .sampleOut(sampleOut)
);

// File: tb/alc_core_test.sv
module alc_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        alcEnable = 1'b0;
  logic [1:0]  thrSel = '0, waitSel = '0, stepSel = '0;
  logic [7:0]  refGain = 8'd145, manualGain = 8'd145;
  logic [15:0] sampleOut;
  logic        outValid;
  logic [7:0]  gainCode;
  int errors = 0, checks = 0;
  logic [15:0] lastOut;

  always #4 clk = ~clk;

  alc_core uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .alcEnable(alcEnable), .thrSel(thrSel), .waitSel(waitSel), .stepSel(stepSel),
    .refGain(refGain), .manualGain(manualGain), .sampleOut(sampleOut),
    .outValid(outValid), .gainCode(gainCode)
  );

  // {gain code, input, expected output}
  localparam logic [39:0] VEC [12] = '{
    {8'd145, 16'h03E8, 16'h03E8},
    {8'd145, 16'hCFC7, 16'hCFC7},
    {8'd161, 16'h03E8, 16'h07D0},
    {8'd129, 16'h03E9, 16'h01F4},
    {8'd129, 16'hFC17, 16'hFE0B},
    {8'd1,   16'h1400, 16'h000A},
    {8'd241, 16'h0064, 16'h1900},
    {8'd250, 16'h0064, 16'h1900},
    {8'd177, 16'hFED4, 16'hFB50},
    {8'd241, 16'h03E8, 16'h7FFF},
    {8'd241, 16'hFC18, 16'h8000},
    {8'd0,   16'h3039, 16'h0000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(input logic [15:0] x);
    @(negedge clk);
    sampleIn = x;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    lastOut = sampleOut;
    check("R2 outValid", int'(outValid), 1);
  endtask

  task automatic setManual(input logic [7:0] g);
    @(negedge clk);
    alcEnable = 1'b0;
    manualGain = g;
    @(negedge clk);
  endtask

  task automatic smalls(input int n);
    for (int i = 0; i < n; i++) sendSample(16'd100);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 gain", int'(gainCode), 145);
    check("R10 valid", int'(outValid), 0);
    check("R10 out", int'(sampleOut), 0);
    rstN = 1'b1;

    // R5 manual volume
    setManual(8'd100);
    check("R5 manual", int'(gainCode), 100);

    // gain table walk: R1 exact powers, R3 saturation, R4 mute
    for (int i = 0; i < 12; i++) begin
      string tag;
      setManual(VEC[i][39:32]);
      sendSample(VEC[i][31:16]);
      if (VEC[i][39:32] == 8'd0) tag = "R4 mute";
      else if (VEC[i][15:0] == 16'h7FFF || VEC[i][15:0] == 16'h8000) tag = "R3 saturate";
      else tag = "R1 table";
      check(tag, int'($signed(lastOut)), int'($signed(VEC[i][15:0])));
    end
    @(negedge clk);
    check("R2 strobe low", int'(outValid), 0);

    // limiter and recovery, W=4, step 1, ref 163, threshold 16384
    thrSel = 2'd0; waitSel = 2'd0; stepSel = 2'd0; refGain = 8'd163;
    setManual(8'd161);
    alcEnable = 1'b1;
    sendSample(16'd10000);
    check("R6 limit first", int'(gainCode), 160);
    check("R6 output", int'(lastOut), 20000);
    sendSample(16'd10000);
    check("R6 limit again", int'(gainCode), 159);
    smalls(3);
    check("R7 still waiting", int'(gainCode), 159);
    repeat (10) @(negedge clk);
    check("R9 idle hold", int'(gainCode), 159);
    smalls(1);
    check("R7 recover", int'(gainCode), 160);
    smalls(12);
    check("R8 reach ref", int'(gainCode), 163);
    smalls(4);
    check("R8 hold at ref", int'(gainCode), 163);
    smalls(2);
    sendSample(16'd10000);
    check("R6 limit mid-wait", int'(gainCode), 162);
    smalls(3);
    check("R7 wait restarted", int'(gainCode), 162);
    smalls(1);
    check("R7 recover after restart", int'(gainCode), 163);

    // step size 4, W=8, ref 170
    alcEnable = 1'b0;
    waitSel = 2'd1; stepSel = 2'd3; refGain = 8'd170;
    setManual(8'd160);
    alcEnable = 1'b1;
    smalls(7);
    check("R7 wait 8", int'(gainCode), 160);
    smalls(1);
    check("R8 step 4", int'(gainCode), 164);
    smalls(8);
    check("R8 step 4 again", int'(gainCode), 168);
    smalls(8);
    check("R8 clamp ref", int'(gainCode), 170);
    smalls(8);
    check("R8 stay ref", int'(gainCode), 170);

    // disabling returns control to manual volume
    setManual(8'd120);
    check("R5 back to manual", int'(gainCode), 120);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule